// File: doc/BRIEF.md
# Mode-Switched Shadow Register File

This block is a 64-bit integer register file with thirty-two architectural indices, two combinational read ports and one clocked write port. Next to the main array it keeps a hidden bank of eight shadow registers. A privileged-mode input decides where a handful of indices land: while it is high, indices 8 to 14 and index 25 are steered into the shadow bank, so privileged code gets private scratch registers without saving the ordinary ones. While it is low, every index reaches the main array and the shadow contents stay put, out of sight.

The same steering is applied independently to each of the three ports, so a read and a write in one cycle may hit different banks. Index 31 is a hardwired zero. There is no bypass from the write port to the read ports. Reads show the stored value until the clock edge that commits the write.

Being pure storage plus decode, the block has no sequencing of its own. Its only states are the privileged flag, which is an input, and the contents of the two banks.

Top module: `shreg_file`

## Requirements
- R1: After reset every main entry and every shadow entry reads as zero, in either mode.
- R2: Each read port returns, in the same cycle and without a clock edge, the 64-bit value stored at the entry its 5-bit index selects; the two ports are independent.
- R3: With the write enable high, the write data is stored at the rising clock edge into the entry the write index selects. With the enable low, no entry changes.
- R4: With the privileged input high, indices 8, 9, 10, 11, 12, 13 and 14 select shadow entries 0 to 6 in that order. These are storage separate from main entries 8 to 14.
- R5: With the privileged input high, index 25 selects shadow entry 7, separate from main entry 25.
- R6: With the privileged input high, every index other than 8 to 14, 25 and 31 selects the same main entry it selects with the input low.
- R7: With the privileged input low, all indices select the main array, no write reaches the shadow bank, and shadow contents are kept until the mode returns.
- R8: Index 31 always reads as zero and a write to it changes no entry, in either mode.
- R9: A read of the entry being written in the same cycle returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both banks |
| priv_i | input | 1 | Privileged mode; enables steering into the shadow bank |
| rd_a_idx_i | input | 5 | Read port A register index |
| rd_a_data_o | output | 64 | Read port A data |
| rd_b_idx_i | input | 5 | Read port B register index |
| rd_b_data_o | output | 64 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | 64 | Write data |

## Verification
The hardest situation to reach from the ports is one where the main and shadow copies of an aliased index hold different values at once. A write in only one mode looks the same as a shared register. The bench writes distinct values to the same index in each mode and then reads it back in both modes. Its random phase biases indices toward 8 to 14, 25 and 31 and toggles the mode often, so that writes and reads to aliased entries cross the mode change, also in the same cycle.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int XLEN_DEF   = 64;
    localparam int IDXW       = 5;
    localparam int NREG_DEF   = 32;
    localparam int NSHAD_DEF  = 8;
    localparam int ZERO_IDX   = 31;

    // Port roles for the per-port steering instances
    typedef enum logic [1:0] {
        PORT_WR  = 2'd0,
        PORT_RDA = 2'd1,
        PORT_RDB = 2'd2
    } port_role_e;

    localparam int NPORTS = 3;

endpackage

// File: rtl/shreg_route.sv
module shreg_route
    import shreg_pkg::*;
#(
    parameter int WIN_LO = 8,
    parameter int WIN_HI = 14,
    parameter int EXTRA  = 25,
    parameter int NSHAD  = NSHAD_DEF,
    localparam int SLOTW = $clog2(NSHAD)
) (
    input  logic              priv_i,
    input  logic [IDXW-1:0]   idx_i,
    output logic              to_shadow_o,
    output logic [SLOTW-1:0]  slot_o,
    output logic              is_zero_o
);

    logic in_window;
    logic is_extra;

    always_comb begin
        in_window   = (int'(idx_i) >= WIN_LO) && (int'(idx_i) <= WIN_HI);
        is_extra    = (int'(idx_i) == EXTRA);
        is_zero_o   = (int'(idx_i) == ZERO_IDX);
        to_shadow_o = priv_i && (in_window || is_extra);
        if (is_extra) begin
            slot_o = SLOTW'(NSHAD - 1);
        end else begin
            slot_o = SLOTW'(int'(idx_i) - WIN_LO);
        end
    end

endmodule

// File: rtl/shreg_bank.sv
module shreg_bank #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_a_i,
    input  logic [AW-1:0]    raddr_b_i,
    output logic [WIDTH-1:0] rdata_a_o,
    output logic [WIDTH-1:0] rdata_b_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= '0;
            end
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_a_o = mem[raddr_a_i];
        rdata_b_o = mem[raddr_b_i];
    end

endmodule

// File: rtl/shreg_file.sv
module shreg_file
    import shreg_pkg::*;
#(
    parameter int XLEN   = XLEN_DEF,
    parameter int NREG   = NREG_DEF,
    parameter int NSHAD  = NSHAD_DEF,
    parameter int WIN_LO = 8,
    parameter int WIN_HI = 14,
    parameter int EXTRA  = 25,
    localparam int SLOTW = $clog2(NSHAD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic [IDXW-1:0]   rd_a_idx_i,
    output logic [XLEN-1:0]   rd_a_data_o,
    input  logic [IDXW-1:0]   rd_b_idx_i,
    output logic [XLEN-1:0]   rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [IDXW-1:0]   wr_idx_i,
    input  logic [XLEN-1:0]   wr_data_i
);

    logic [IDXW-1:0]  port_idx  [NPORTS];
    logic             port_shad [NPORTS];
    logic [SLOTW-1:0] port_slot [NPORTS];
    logic             port_zero [NPORTS];

    assign port_idx[PORT_WR]  = wr_idx_i;
    assign port_idx[PORT_RDA] = rd_a_idx_i;
    assign port_idx[PORT_RDB] = rd_b_idx_i;

    // One steering decoder per port
    for (genvar p = 0; p < NPORTS; p++) begin : g_route
        shreg_route #(
            .WIN_LO (WIN_LO),
            .WIN_HI (WIN_HI),
            .EXTRA  (EXTRA),
            .NSHAD  (NSHAD)
        ) i_route (
            .priv_i      (priv_i),
            .idx_i       (port_idx[p]),
            .to_shadow_o (port_shad[p]),
            .slot_o      (port_slot[p]),
            .is_zero_o   (port_zero[p])
        );
    end

    logic main_we;
    logic shad_we;

    always_comb begin
        main_we = wr_en_i && !port_shad[PORT_WR] && !port_zero[PORT_WR];
        shad_we = wr_en_i &&  port_shad[PORT_WR];
    end

    logic [XLEN-1:0] main_qa, main_qb, shad_qa, shad_qb;

    shreg_bank #(.WIDTH(XLEN), .DEPTH(NREG)) i_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (main_we),
        .waddr_i   (wr_idx_i),
        .wdata_i   (wr_data_i),
        .raddr_a_i (rd_a_idx_i),
        .raddr_b_i (rd_b_idx_i),
        .rdata_a_o (main_qa),
        .rdata_b_o (main_qb)
    );

    shreg_bank #(.WIDTH(XLEN), .DEPTH(NSHAD)) i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (shad_we),
        .waddr_i   (port_slot[PORT_WR]),
        .wdata_i   (wr_data_i),
        .raddr_a_i (port_slot[PORT_RDA]),
        .raddr_b_i (port_slot[PORT_RDB]),
        .rdata_a_o (shad_qa),
        .rdata_b_o (shad_qb)
    );

    always_comb begin
        if (port_zero[PORT_RDA])      rd_a_data_o = '0;
        else if (port_shad[PORT_RDA]) rd_a_data_o = shad_qa;
        else                          rd_a_data_o = main_qa;

        if (port_zero[PORT_RDB])      rd_b_data_o = '0;
        else if (port_shad[PORT_RDB]) rd_b_data_o = shad_qb;
        else                          rd_b_data_o = main_qb;
    end

    // ---------------- assertions ----------------

    // R7: no shadow write outside privileged mode
    p_no_shadow_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_i |-> !shad_we);

    // R6: a write lands in at most one bank
    p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_we, shad_we}));

    // R8: index 31 reads zero on both ports
    p_zero_read_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_a_idx_i) == ZERO_IDX) |-> (rd_a_data_o == '0));
    p_zero_read_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_b_idx_i) == ZERO_IDX) |-> (rd_b_data_o == '0));

    // R3: a committed write is seen next cycle by a read in the same mode
    p_write_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_idx_i) != ZERO_IDX) |=>
        ((rd_a_idx_i == $past(wr_idx_i) && priv_i == $past(priv_i))
            -> (rd_a_data_o == $past(wr_data_i))));

    // R3: without a write, an unchanged read selection returns unchanged data
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && $stable(rd_b_idx_i) && $stable(priv_i))
            |-> $stable(rd_b_data_o));

endmodule

// File: tb/test_shreg_file.sv
module test_shreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv = 1'b0;
    logic [4:0]  ra = '0, rb = '0, wi = '0;
    logic        we = 1'b0;
    logic [63:0] wd = '0;
    logic [63:0] qa, qb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] main_m [32];
    logic [63:0] shad_m [8];

    always #4 clk = ~clk;

    shreg_file i_shreg_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_i      (priv),
        .rd_a_idx_i  (ra),
        .rd_a_data_o (qa),
        .rd_b_idx_i  (rb),
        .rd_b_data_o (qb),
        .wr_en_i     (we),
        .wr_idx_i    (wi),
        .wr_data_i   (wd)
    );

    function automatic bit aliased(bit p, logic [4:0] i);
        return p && ((i >= 5'd8 && i <= 5'd14) || i == 5'd25);
    endfunction

    function automatic int slot_of(logic [4:0] i);
        return (i == 5'd25) ? 7 : int'(i) - 8;
    endfunction

    function automatic logic [63:0] exp_rd(bit p, logic [4:0] i);
        if (i == 5'd31) return 64'd0;
        if (aliased(p, i)) return shad_m[slot_of(i)];
        return main_m[i];
    endfunction

    function automatic string tag_of(bit p, logic [4:0] i);
        if (i == 5'd31) return "R8";
        if (p && i == 5'd25) return "R5";
        if (aliased(p, i)) return "R4";
        if (!p && ((i >= 5'd8 && i <= 5'd14) || i == 5'd25)) return "R7";
        if (p) return "R6";
        return "R2";
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check reads before the edge, update model at the edge
    task automatic step(bit p, bit e, logic [4:0] w, logic [63:0] d,
                        logic [4:0] a, logic [4:0] b);
        @(negedge clk);
        priv = p; we = e; wi = w; wd = d; ra = a; rb = b;
        #1;
        check((e && w == a) ? "R9" : tag_of(p, a), qa, exp_rd(p, a));
        check((e && w == b) ? "R9" : tag_of(p, b), qb, exp_rd(p, b));
        @(posedge clk);
        if (e && w != 5'd31) begin
            if (aliased(p, w)) shad_m[slot_of(w)] = d;
            else               main_m[w] = d;
        end
    endtask

    task automatic peek(bit p, logic [4:0] a, string req, logic [63:0] exp);
        @(negedge clk);
        priv = p; we = 1'b0; ra = a; rb = a;
        #1;
        check(req, qa, exp);
        check(req, qb, exp);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int k = 0; k < 32; k++) main_m[k] = '0;
        for (int k = 0; k < 8; k++)  shad_m[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset, both modes
        for (int k = 0; k < 32; k++) begin
            peek(1'b0, 5'(k), "R1", 64'd0);
            peek(1'b1, 5'(k), "R1", 64'd0);
        end

        // R3: write commits, disabled write leaves entry alone
        step(1'b0, 1'b1, 5'd5, 64'hA5A5_0000_1111_2222, 5'd0, 5'd1);
        peek(1'b0, 5'd5, "R3", 64'hA5A5_0000_1111_2222);
        step(1'b0, 1'b0, 5'd5, 64'hDEAD_BEEF_0000_0001, 5'd5, 5'd5);
        peek(1'b0, 5'd5, "R3", 64'hA5A5_0000_1111_2222);

        // R9: same-cycle read of the written entry returns the old value
        step(1'b0, 1'b1, 5'd5, 64'h0123_4567_89AB_CDEF, 5'd5, 5'd5);
        peek(1'b0, 5'd5, "R9", 64'h0123_4567_89AB_CDEF);

        // R4: index 9 holds separate values per mode
        step(1'b1, 1'b1, 5'd9, 64'h5555_AAAA_5555_AAAA, 5'd0, 5'd0);
        step(1'b0, 1'b1, 5'd9, 64'h1234_0000_0000_4321, 5'd0, 5'd0);
        peek(1'b1, 5'd9, "R4", 64'h5555_AAAA_5555_AAAA);
        peek(1'b0, 5'd9, "R4", 64'h1234_0000_0000_4321);

        // R5: index 25 in privileged mode is shadow entry 7
        step(1'b1, 1'b1, 5'd25, 64'hFEED_FACE_CAFE_F00D, 5'd0, 5'd0);
        peek(1'b0, 5'd25, "R5", 64'd0);
        peek(1'b1, 5'd25, "R5", 64'hFEED_FACE_CAFE_F00D);

        // R6: non-aliased index written in privileged mode is shared
        step(1'b1, 1'b1, 5'd3, 64'h0000_3333_0000_3333, 5'd0, 5'd0);
        peek(1'b0, 5'd3, "R6", 64'h0000_3333_0000_3333);
        peek(1'b1, 5'd15, "R6", 64'd0);

        // R7: shadow value kept across a stretch of user-mode traffic
        step(1'b0, 1'b1, 5'd14, 64'h7777_0000_7777_0000, 5'd14, 5'd9);
        peek(1'b1, 5'd14, "R7", 64'd0);
        peek(1'b1, 5'd9, "R7", 64'h5555_AAAA_5555_AAAA);

        // R8: writes to index 31 vanish in either mode
        step(1'b0, 1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 5'd31);
        step(1'b1, 1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 5'd31);
        peek(1'b0, 5'd31, "R8", 64'd0);
        peek(1'b1, 5'd31, "R8", 64'd0);

        // Random phase biased toward aliased indices and frequent mode flips
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] pick [3];
            for (int q = 0; q < 3; q++) begin
                case ($urandom_range(0, 3))
                    0: pick[q] = 5'($urandom_range(8, 14));
                    1: pick[q] = ($urandom_range(0, 1) != 0) ? 5'd25 : 5'd31;
                    default: pick[q] = 5'($urandom_range(0, 31));
                endcase
            end
            step(($urandom_range(0, 1) != 0), ($urandom_range(0, 3) != 0),
                 pick[0], {$urandom(), $urandom()}, pick[1], pick[2]);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule